// File: doc/BRIEF.md
# 8-bit CPU Effective Address Generator

This block works out the 16-bit effective address of a memory operand for an 8-bit processor core. When it is started it takes an addressing-mode code, the one or two operand bytes of the instruction and the X and Y index registers. It returns the effective address, and it also flags when adding the index carried the address into a different 256-byte page. The execute stage can use that flag to charge the extra cycle.

Zero-page and absolute modes, with or without an index, are resolved arithmetically in one cycle. The two indirect modes first read a little-endian pointer through a byte-wide read port. Each byte uses a request/valid handshake. Fetching the operand itself and executing the instruction are left to the surrounding core.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (zero page) gives `ea_o = {8'h00, op_lo_i}` with `page_cross_o = 0`, and `done_o` rises in the cycle right after the accepting clock edge.
- R2: Mode codes 1 (zero page + X) and 2 (zero page + Y) give `ea_o = {8'h00, (op_lo_i + index) mod 256}`, so the result wraps inside page zero. `page_cross_o` is 0. Neither mode issues a memory read.
- R3: Mode code 3 (absolute) gives `ea_o = {op_hi_i, op_lo_i}`, with `page_cross_o = 0` and no memory read.
- R4: Mode codes 4 (absolute + X) and 5 (absolute + Y) give `ea_o = ({op_hi_i, op_lo_i} + index) mod 65536`. `page_cross_o` is 1 exactly when the upper byte of the result differs from `op_hi_i`.
- R5: Mode code 6 (indexed-indirect) forms `p = (op_lo_i + X) mod 256`. It reads the pointer low byte at address `{8'h00, p}` and the high byte at that address plus one, computed in 16 bits, so p = 0xFF reads 0x0100. `ea_o` is the assembled pointer and `page_cross_o` is 0.
- R6: Mode code 7 (indirect-indexed) reads the pointer low byte at `{8'h00, op_lo_i}` and the high byte at that address plus one, computed in 16 bits. It then gives `ea_o = pointer + Y`. `page_cross_o` is 1 when the upper byte changes.
- R7: `rd_req_o` holds, with `rd_addr_o` stable, until `rd_valid_i` is seen at a clock edge. Only one read is outstanding at a time, and the low byte is always read before the high byte. With a read latency of L idle cycles per byte, `done_o` is seen 2·(L+1)+1 cycles after the start edge.
- R8: `done_o` is high for exactly one cycle per accepted start. `ea_o`, `page_cross_o` and `err_o` then hold their values until the next accepted start.
- R9: Mode codes 8 to 15 are unsupported. They produce `done_o` one cycle after start, with `err_o = 1`, `ea_o = 0`, `page_cross_o = 0`, and no read. Supported modes give `err_o = 0`.
- R10: `start_i` while `busy_o` is high is ignored: no extra `done_o` pulse, and the result of the running operation is unchanged.
- R11: After reset, `done_o`, `busy_o`, `rd_req_o`, `err_o`, `page_cross_o` and `ea_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when not busy |
| mode_i | input | 4 | Addressing-mode code |
| op_lo_i | input | 8 | First operand byte |
| op_hi_i | input | 8 | Second operand byte (absolute modes) |
| idx_x_i | input | 8 | X index register |
| idx_y_i | input | 8 | Y index register |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 16 | Read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Pointer fetch in progress |
| ea_o | output | 16 | Effective address |
| page_cross_o | output | 1 | Index addition changed the page |
| err_o | output | 1 | Unsupported mode code |

## Verification
Zero-page indexed modes are driven with sums below and above 0xFF. This separates an 8-bit wrap from a full 16-bit add. Absolute indexed modes use bases that do and do not carry into the upper byte, which pins down the page flag for both X and Y. The indirect modes run with read latencies 0, 1 and 3. Some use pointer locations at 0xFF, which shows the successor read lands at 0x0100. Others use a pointer plus Y that crosses a page, which ties the flag to the pointer rather than the operand. The logged read addresses and the completion cycle count check the handshake order and timing. A mid-fetch start and an unsupported mode code check the ignore and error paths.

// File: rtl/ea_gen_pkg.sv
`timescale 1ns/1ps
package ea_gen_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_INDX = 4'd6,
    AM_INDY = 4'd7
  } am_e;

  typedef struct packed {
    logic ok;
    logic ind;
    logic use_x;
    logic use_y;
    logic zp;
    logic pc_en;
  } am_dec_t;

  function automatic am_dec_t am_decode(logic [MODE_W-1:0] m);
    am_dec_t d;
    d = '0;
    case (m)
      AM_ZP:   begin d.ok = 1'b1; d.zp = 1'b1; end
      AM_ZPX:  begin d.ok = 1'b1; d.zp = 1'b1; d.use_x = 1'b1; end
      AM_ZPY:  begin d.ok = 1'b1; d.zp = 1'b1; d.use_y = 1'b1; end
      AM_ABS:  begin d.ok = 1'b1; end
      AM_ABSX: begin d.ok = 1'b1; d.use_x = 1'b1; d.pc_en = 1'b1; end
      AM_ABSY: begin d.ok = 1'b1; d.use_y = 1'b1; d.pc_en = 1'b1; end
      AM_INDX: begin d.ok = 1'b1; d.ind = 1'b1; d.use_x = 1'b1; end
      AM_INDY: begin d.ok = 1'b1; d.ind = 1'b1; d.use_y = 1'b1; d.pc_en = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ea_index_add.sv
`timescale 1ns/1ps
module ea_index_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base_i,
  input  logic [DW-1:0]   idx_i,
  input  logic            zp_wrap_i,
  output logic [2*DW-1:0] sum_o,
  output logic            cross_o
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] full_sum;
  logic [DW-1:0] low_sum;

  assign full_sum = base_i + {{DW{1'b0}}, idx_i};
  assign low_sum  = base_i[DW-1:0] + idx_i;
  assign sum_o    = zp_wrap_i ? {{DW{1'b0}}, low_sum} : full_sum;
  assign cross_o  = !zp_wrap_i && (full_sum[AW-1:DW] != base_i[AW-1:DW]);
endmodule

// File: rtl/ea_ptr_seq.sv
`timescale 1ns/1ps
module ea_ptr_seq #(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DW-1:0]   zp_i,
  output logic            rd_req_o,
  output logic [2*DW-1:0] rd_addr_o,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic [2*DW-1:0] ptr_o,
  output logic            ptr_vld_o
);
  localparam int AW = 2 * DW;

  typedef enum logic [1:0] {PS_IDLE, PS_LO, PS_HI} ps_e;

  ps_e           state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      case (state_q)
        PS_IDLE: if (start_i) begin
          addr_q  <= {{DW{1'b0}}, zp_i};
          state_q <= PS_LO;
        end
        PS_LO: if (rd_valid_i) begin
          lo_q    <= rd_data_i;
          addr_q  <= addr_q + 1'b1;  // 16-bit successor, no page-zero wrap
          state_q <= PS_HI;
        end
        PS_HI: if (rd_valid_i) state_q <= PS_IDLE;
        default: state_q <= PS_IDLE;
      endcase
    end
  end

  assign rd_req_o  = (state_q != PS_IDLE);
  assign rd_addr_o = addr_q;
  assign ptr_vld_o = (state_q == PS_HI) && rd_valid_i;
  assign ptr_o     = {rd_data_i, lo_q};

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

  // R7
  succ_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_LO) && rd_valid_i |=> rd_req_o && (rd_addr_o == $past(rd_addr_o) + 1'b1));
endmodule

// File: rtl/ea_gen.sv
`timescale 1ns/1ps
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DW-1:0]     op_lo_i,
  input  logic [DW-1:0]     op_hi_i,
  input  logic [DW-1:0]     idx_x_i,
  input  logic [DW-1:0]     idx_y_i,
  output logic              rd_req_o,
  output logic [2*DW-1:0]   rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic              done_o,
  output logic              busy_o,
  output logic [2*DW-1:0]   ea_o,
  output logic              page_cross_o,
  output logic              err_o
);
  localparam int AW = 2 * DW;

  am_dec_t           dec_in, dec_q;
  logic [MODE_W-1:0] mode_q;
  logic [DW-1:0]     y_q;
  logic              busy_q, done_q, pc_q, err_q;
  logic [AW-1:0]     ea_q;
  logic              start_acc, seq_start, ptr_vld;
  logic [AW-1:0]     ptr;
  logic [AW-1:0]     add_base, add_sum;
  logic [DW-1:0]     add_idx, zp_ptr;
  logic              add_wrap, add_cross;

  assign dec_in    = am_decode(mode_i);
  assign dec_q     = am_decode(mode_q);
  assign start_acc = start_i && !busy_q;
  assign seq_start = start_acc && dec_in.ind;
  assign zp_ptr    = dec_in.use_x ? (op_lo_i + idx_x_i) : op_lo_i;

  ea_ptr_seq #(.DW(DW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (seq_start),
    .zp_i       (zp_ptr),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .ptr_o      (ptr),
    .ptr_vld_o  (ptr_vld)
  );

  // One adder shared by the direct path and the pointer-complete path
  always_comb begin
    if (ptr_vld) begin
      add_base = ptr;
      add_idx  = dec_q.use_y ? y_q : '0;
      add_wrap = 1'b0;
    end else begin
      add_base = dec_in.zp ? {{DW{1'b0}}, op_lo_i} : {op_hi_i, op_lo_i};
      add_idx  = dec_in.use_x ? idx_x_i : (dec_in.use_y ? idx_y_i : '0);
      add_wrap = dec_in.zp;
    end
  end

  ea_index_add #(.DW(DW)) u_add (
    .base_i    (add_base),
    .idx_i     (add_idx),
    .zp_wrap_i (add_wrap),
    .sum_o     (add_sum),
    .cross_o   (add_cross)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      y_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ea_q   <= '0;
      pc_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (start_acc) begin
      mode_q <= mode_i;
      y_q    <= idx_y_i;
      if (dec_in.ind) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else begin
        done_q <= 1'b1;
        ea_q   <= dec_in.ok ? add_sum : '0;
        pc_q   <= dec_in.ok && dec_in.pc_en && add_cross;
        err_q  <= !dec_in.ok;
      end
    end else if (ptr_vld) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      ea_q   <= add_sum;
      pc_q   <= dec_q.pc_en && add_cross;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o       = done_q;
  assign busy_o       = busy_q;
  assign ea_o         = ea_q;
  assign page_cross_o = pc_q;
  assign err_o        = err_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ea_o == '0) && !page_cross_o);

  // R2
  zp_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && dec_q.zp |-> (ea_o[AW-1:DW] == '0) && !page_cross_o);

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_q) && !done_o || ($past(busy_o) && !busy_o));

  // R7
  no_read_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !rd_req_o |=> !rd_req_o || busy_o);
endmodule

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, ix = '0, iy = '0;
  logic        rd_req, rd_valid = 1'b0;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        done, busy, pc, err;
  logic [15:0] ea;

  int vectors = 0;
  int fails = 0;
  int lat_cfg = 0;
  int lat_cnt = 0;
  int rd_n = 0;
  logic [15:0] rd_log [0:3];
  logic [7:0]  mem [0:511];

  logic [15:0] g_ea;
  logic        g_pc, g_err;
  int          g_cyc;

  always #10 clk = ~clk;

  ea_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .op_lo_i(op_lo), .op_hi_i(op_hi), .idx_x_i(ix), .idx_y_i(iy),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .done_o(done), .busy_o(busy), .ea_o(ea), .page_cross_o(pc), .err_o(err)
  );

  // Memory model with configurable idle cycles before each byte
  always @(negedge clk) begin
    if (rd_req) begin
      if (lat_cnt >= lat_cfg) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[rd_addr[8:0]];
        if (rd_n < 4) rd_log[rd_n] = rd_addr;
        rd_n++;
        lat_cnt = 0;
      end else begin
        rd_valid <= 1'b0;
        lat_cnt++;
      end
    end else begin
      rd_valid <= 1'b0;
      lat_cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] x, input logic [7:0] y, input int lat);
    @(negedge clk);
    mode = m; op_lo = lo; op_hi = hi; ix = x; iy = y;
    lat_cfg = lat; rd_n = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    g_cyc = 1;
    while (!done && g_cyc < 60) begin
      @(negedge clk);
      g_cyc++;
    end
    g_ea = ea; g_pc = pc; g_err = err;
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
    chk("R8 ea held", {16'd0, ea}, {16'd0, g_ea});
  endtask

  task automatic t_reset();
    chk("R11 done", {31'd0, done}, 0);
    chk("R11 busy", {31'd0, busy}, 0);
    chk("R11 rd_req", {31'd0, rd_req}, 0);
    chk("R11 ea/pc/err", {13'd0, err, pc, ea}, 0);
  endtask

  task automatic t_zp();
    run_op(4'd0, 8'hA7, 8'h55, 8'h10, 8'h20, 0);
    chk("R1 ea", {16'd0, g_ea}, 32'h00A7);
    chk("R1 pc", {31'd0, g_pc}, 0);
    chk("R1 latency", g_cyc, 1);
  endtask

  task automatic t_zp_idx();
    run_op(4'd1, 8'h30, 8'h99, 8'h12, 8'hFF, 0);
    chk("R2 zpx no wrap", {16'd0, g_ea}, 32'h0042);
    run_op(4'd1, 8'hF0, 8'h99, 8'h20, 8'h00, 0);
    chk("R2 zpx wrap", {16'd0, g_ea}, 32'h0010);
    chk("R2 zpx pc", {31'd0, g_pc}, 0);
    run_op(4'd2, 8'hC8, 8'h00, 8'h01, 8'h40, 0);
    chk("R2 zpy wrap", {16'd0, g_ea}, 32'h0008);
    chk("R2 no read", rd_n, 0);
  endtask

  task automatic t_abs();
    run_op(4'd3, 8'h34, 8'h12, 8'hFF, 8'hFF, 0);
    chk("R3 ea", {16'd0, g_ea}, 32'h1234);
    chk("R3 pc/err", {30'd0, g_pc, g_err}, 0);
    chk("R3 no read", rd_n, 0);
  endtask

  task automatic t_abs_idx();
    run_op(4'd4, 8'h10, 8'h20, 8'h05, 8'hF0, 0);
    chk("R4 absx same page", {15'd0, g_pc, g_ea}, 32'h0_2015);
    run_op(4'd4, 8'hF0, 8'h20, 8'h20, 8'h00, 0);
    chk("R4 absx cross", {15'd0, g_pc, g_ea}, 32'h1_2110);
    run_op(4'd5, 8'hFF, 8'hFF, 8'h00, 8'h01, 0);
    chk("R4 absy wrap 64K", {15'd0, g_pc, g_ea}, 32'h1_0000);
    run_op(4'd5, 8'h00, 8'h80, 8'h77, 8'hFF, 0);
    chk("R4 absy same page", {15'd0, g_pc, g_ea}, 32'h0_80FF);
  endtask

  task automatic t_indx();
    mem[9'h012] = 8'hCD; mem[9'h013] = 8'hAB;
    run_op(4'd6, 8'hF2, 8'h00, 8'h20, 8'hFF, 0);
    chk("R5 ptr value", {15'd0, g_pc, g_ea}, 32'h0_ABCD);
    chk("R7 reads lo addr", {16'd0, rd_log[0]}, 32'h0012);
    chk("R7 reads hi addr", {16'd0, rd_log[1]}, 32'h0013);
    chk("R7 latency L0", g_cyc, 3);
    mem[9'h0FF] = 8'h78; mem[9'h100] = 8'h56;
    run_op(4'd6, 8'hF0, 8'h00, 8'h0F, 8'h00, 1);
    chk("R5 ptr at FF", {16'd0, g_ea}, 32'h5678);
    chk("R5 successor 0100", {16'd0, rd_log[1]}, 32'h0100);
    chk("R7 latency L1", g_cyc, 5);
  endtask

  task automatic t_indy();
    mem[9'h040] = 8'hF0; mem[9'h041] = 8'h12;
    run_op(4'd7, 8'h40, 8'h00, 8'h99, 8'h20, 0);
    chk("R6 cross", {15'd0, g_pc, g_ea}, 32'h1_1310);
    run_op(4'd7, 8'h40, 8'h00, 8'h99, 8'h05, 3);
    chk("R6 no cross", {15'd0, g_pc, g_ea}, 32'h0_12F5);
    chk("R7 latency L3", g_cyc, 9);
    chk("R7 read count", rd_n, 2);
    run_op(4'd7, 8'hFF, 8'h00, 8'h00, 8'h01, 0);
    chk("R6 ptr at FF", {15'd0, g_pc, g_ea}, 32'h0_5679);
  endtask

  task automatic t_bad_mode();
    run_op(4'd11, 8'h12, 8'h34, 8'h01, 8'h01, 0);
    chk("R9 err", {31'd0, g_err}, 1);
    chk("R9 ea/pc zero", {15'd0, g_pc, g_ea}, 0);
    chk("R9 latency", g_cyc, 1);
    chk("R9 no read", rd_n, 0);
    run_op(4'd0, 8'h01, 8'h00, 8'h00, 8'h00, 0);
    chk("R9 err clears", {31'd0, g_err}, 0);
  endtask

  task automatic t_busy_ignore();
    int dones;
    int cyc;
    dones = 0;
    @(negedge clk);
    mode = 4'd7; op_lo = 8'h40; iy = 8'h20; lat_cfg = 2; rd_n = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy", {31'd0, busy}, 1);
    @(negedge clk);
    mode = 4'd0; op_lo = 8'h77; iy = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (cyc = 0; cyc < 20; cyc++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk("R10 single done", dones, 1);
    chk("R10 result kept", {15'd0, pc, ea}, 32'h1_1310);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_zp();
    t_zp_idx();
    t_abs();
    t_abs_idx();
    t_indx();
    t_indy();
    t_bad_mode();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule